// File: doc/BRIEF.md
# Bipolar Stepper Motor Pulse Generator

The block drives the two coil terminals of a bipolar stepping motor in a quartz watch. All timing advances on a timebase tick, normally the 32 kHz oscillator divided down to a single-cycle enable. Every motor period it issues one drive pulse of a programmed width in ticks. While a pulse is active one terminal is high and the other low. Between pulses both terminals are low. The polarity of the pulse flips after every completed pulse, and the first pulse after reset drives the first coil terminal, so the motor starts in a known phase.

Two digital flags carry the battery state from analog comparators outside this block. The block samples them on a slow schedule and turns them into one of three operating modes. With a lithium cell the pulse is chopped so that it stays on for three of every four ticks. With a silver-oxide cell the pulse is driven solidly. At end-of-life the pulse is also solid, but pulses are sent only as a group of four every fourth period, which shows the user that the cell is nearly empty. A halt request releases both terminals to high impedance and restarts the period timing, so the hands can be set accurately.

Top module: `step_drive`

## Requirements
- R1: While reset is held, both coil outputs are low and both output enables are high. After reset the sampled mode is silver-oxide and the pulse polarity is positive.
- R2: The first drive pulse after reset drives `coil_a` high and leaves `coil_b` low.
- R3: Each completed pulse inverts the polarity of the next one. Both coils are low outside pulses, and the two coils are never high together.
- R4: A pulse starts on the tick that completes each run of `period` ticks, counted from the end of reset or from the release of `halt`. It stays active for `pulse_width` ticks. The coil outputs follow the internal state one clock later.
- R5: In lithium mode the coil is off during every pulse tick whose offset from the pulse start, taken modulo CHOP_LEN (default 4), equals CHOP_LEN-1. It is on for all other pulse ticks.
- R6: The battery flags are sampled only on the FIRST_SAMPLE-th tick after reset and then on every SAMPLE_INTERVAL-th tick. `batt_lith`=1 selects lithium, otherwise `batt_eol`=1 selects end-of-life, otherwise silver-oxide. Flag values between samples have no effect on the pulses.
- R7: In end-of-life mode pulses are unchopped. Only every fourth period boundary (the 4th, 8th, ... since reset or halt release) starts output, and it starts a group of four pulses whose starts are BURST_STEP ticks apart.
- R8: The mode is captured when a pulse starts and held for the whole pulse. A sample that falls on the same tick as a pulse start affects only later pulses.
- R9: While `halt` is high, both output enables and both coils are low from the next clock. A pulse in progress is dropped without inverting polarity, and the period, group and burst timing restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one clock wide |
| pulse_width | input | WW | Pulse length in ticks (at least 1) |
| period | input | PW | Ticks between pulse starts (at least 2) |
| batt_lith | input | 1 | Supply at or above the lithium threshold |
| batt_eol | input | 1 | Supply at or below the end-of-life threshold |
| halt | input | 1 | Stop request, releases the coils |
| coil_a | output | 1 | Coil terminal A drive level |
| coil_b | output | 1 | Coil terminal B drive level |
| coil_a_oe | output | 1 | Output enable for terminal A |
| coil_b_oe | output | 1 | Output enable for terminal B |

## Verification
The case that needs care is a battery sample that lands on the same tick as a period boundary. The bench sets the first sample tick equal to the period, with the lithium flag raised from the start. The first pulse must then come out solid for its full width, because it takes the mode held before the sample, and the next pulse must be chopped. A second collision is a halt that arrives during a pulse. The bench checks that the outputs release at once and that the next pulse after release, exactly one period later, drives the same terminal as the dropped pulse. A tick-level reference model runs alongside the design under random flags, halts, widths and periods, and compares the outputs on every tick.

// File: rtl/step_drive_pkg.sv
package step_drive_pkg;
  typedef enum logic [1:0] {
    BATT_SILVER = 2'd0,
    BATT_LITH   = 2'd1,
    BATT_EOL    = 2'd2
  } batt_mode_t;
endpackage

// File: rtl/batt_mode_sampler.sv
module batt_mode_sampler
  import step_drive_pkg::*;
#(
  parameter int FIRST_SAMPLE    = 983,
  parameter int SAMPLE_INTERVAL = 1966080
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       batt_lith,
  input  logic       batt_eol,
  output batt_mode_t mode
);
  localparam int LIM_MAX = (FIRST_SAMPLE > SAMPLE_INTERVAL) ? FIRST_SAMPLE : SAMPLE_INTERVAL;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt;
  logic          first;
  logic          fire;

  assign fire = tick && (cnt == (first ? CW'(FIRST_SAMPLE - 1) : CW'(SAMPLE_INTERVAL - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      first <= 1'b1;
      mode  <= BATT_SILVER;
    end else if (fire) begin
      cnt   <= '0;
      first <= 1'b0;
      mode  <= batt_lith ? BATT_LITH : (batt_eol ? BATT_EOL : BATT_SILVER);
    end else if (tick) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R6: mode moves only on a sample tick
  assert_mode_only_on_sample_R6: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(mode));
endmodule

// File: rtl/step_scheduler.sv
module step_scheduler
  import step_drive_pkg::*;
#(
  parameter int PW          = 16,
  parameter int BURST_STEP  = 2048,
  parameter int BURST_LEN   = 4,
  parameter int BURST_EVERY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          halt,
  input  logic [PW-1:0] period,
  input  batt_mode_t    mode,
  output logic          start
);
  localparam int BW = $clog2(BURST_STEP + 1);
  localparam int LW = $clog2(BURST_LEN + 1);
  localparam int EW = (BURST_EVERY > 1) ? $clog2(BURST_EVERY) : 1;

  logic [PW-1:0] pcnt;
  logic [EW-1:0] grp;
  logic [LW-1:0] left;
  logic [BW-1:0] bstep;
  logic          bnd, burst_due, in_eol, grp_last;

  assign in_eol    = (mode == BATT_EOL);
  assign grp_last  = (grp == EW'(BURST_EVERY - 1));
  assign bnd       = tick && !halt && (pcnt == period - PW'(1));
  assign burst_due = tick && !halt && (left != '0) && (bstep == BW'(BURST_STEP - 1));
  assign start     = burst_due || (bnd && (!in_eol || grp_last));

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      pcnt  <= '0;
      grp   <= '0;
      left  <= '0;
      bstep <= '0;
    end else if (tick) begin
      pcnt <= bnd ? '0 : pcnt + PW'(1);
      if (bnd) grp <= grp_last ? '0 : grp + EW'(1);
      if (bnd && in_eol && grp_last) begin
        left  <= LW'(BURST_LEN - 1);
        bstep <= '0;
      end else if (left != '0) begin
        if (bstep == BW'(BURST_STEP - 1)) begin
          left  <= left - LW'(1);
          bstep <= '0;
        end else begin
          bstep <= bstep + BW'(1);
        end
      end
    end
  end

  // R9: no pulse may be requested while halted
  assert_halt_no_start_R9: assert property (@(posedge clk) disable iff (rst)
    halt |-> !start);
  // R4: a request only ever coincides with a tick
  assert_start_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    start |-> tick);
endmodule

// File: rtl/pulse_former.sv
module pulse_former
  import step_drive_pkg::*;
#(
  parameter int WW       = 8,
  parameter int CHOP_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          halt,
  input  logic          start,
  input  batt_mode_t    mode,
  input  logic [WW-1:0] pulse_width,
  output logic          drive,
  output logic          pol
);
  localparam int CHW = (CHOP_LEN > 1) ? $clog2(CHOP_LEN) : 1;

  logic           active;
  logic [WW-1:0]  wcnt;
  logic [CHW-1:0] cph;
  batt_mode_t     mlat;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      wcnt   <= '0;
      cph    <= '0;
      mlat   <= BATT_SILVER;
      pol    <= 1'b0;
    end else if (halt) begin
      active <= 1'b0;
    end else if (start && !active) begin
      active <= 1'b1;
      wcnt   <= '0;
      cph    <= '0;
      mlat   <= mode;
    end else if (tick && active) begin
      cph <= (cph == CHW'(CHOP_LEN - 1)) ? '0 : cph + CHW'(1);
      if (wcnt == pulse_width - WW'(1)) begin
        active <= 1'b0;
        pol    <= ~pol;
      end else begin
        wcnt <= wcnt + WW'(1);
      end
    end
  end

  assign drive = active && !((mlat == BATT_LITH) && (cph == CHW'(CHOP_LEN - 1)));

  // R3: a completed pulse flips polarity
  assert_pol_flip_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && !$past(halt)) |-> (pol != $past(pol)));
  // R9: a dropped pulse keeps polarity
  assert_halt_keeps_pol_R9: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pol));
  // R8: the captured mode is held while the pulse runs
  assert_mode_held_R8: assert property (@(posedge clk) disable iff (rst)
    active |=> (!active || $stable(mlat)));
endmodule

// File: rtl/step_drive.sv
module step_drive
  import step_drive_pkg::*;
#(
  parameter int WW              = 8,
  parameter int PW              = 16,
  parameter int CHOP_LEN        = 4,
  parameter int BURST_STEP      = 2048,
  parameter int BURST_LEN       = 4,
  parameter int BURST_EVERY     = 4,
  parameter int FIRST_SAMPLE    = 983,
  parameter int SAMPLE_INTERVAL = 1966080
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [WW-1:0] pulse_width,
  input  logic [PW-1:0] period,
  input  logic          batt_lith,
  input  logic          batt_eol,
  input  logic          halt,
  output logic          coil_a,
  output logic          coil_b,
  output logic          coil_a_oe,
  output logic          coil_b_oe
);
  batt_mode_t mode;
  logic       start, drive, pol, oe_q;

  batt_mode_sampler #(
    .FIRST_SAMPLE(FIRST_SAMPLE), .SAMPLE_INTERVAL(SAMPLE_INTERVAL)
  ) u_sampler (
    .clk(clk), .rst(rst), .tick(tick),
    .batt_lith(batt_lith), .batt_eol(batt_eol), .mode(mode)
  );

  step_scheduler #(
    .PW(PW), .BURST_STEP(BURST_STEP), .BURST_LEN(BURST_LEN), .BURST_EVERY(BURST_EVERY)
  ) u_sched (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt),
    .period(period), .mode(mode), .start(start)
  );

  pulse_former #(
    .WW(WW), .CHOP_LEN(CHOP_LEN)
  ) u_former (
    .clk(clk), .rst(rst), .tick(tick), .halt(halt), .start(start),
    .mode(mode), .pulse_width(pulse_width), .drive(drive), .pol(pol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      coil_a <= 1'b0;
      coil_b <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      coil_a <= drive && !pol && !halt;
      coil_b <= drive &&  pol && !halt;
      oe_q   <= !halt;
    end
  end

  assign coil_a_oe = oe_q;
  assign coil_b_oe = oe_q;

  // R3: never both terminals high
  assert_coils_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(coil_a && coil_b));
  // R9: halt releases the terminals on the next clock
  assert_halt_hiz_R9: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!coil_a_oe && !coil_b_oe && !coil_a && !coil_b));
endmodule

// File: tb/step_drive_test.sv
module step_drive_test;
  localparam int WW = 8, PW = 16, CHOP = 4, BS = 8;
  localparam int FIRST = 40, INTV = 200;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic [WW-1:0] pulse_width = 8'd6;
  logic [PW-1:0] period = 16'd40;
  logic batt_lith = 1'b0, batt_eol = 1'b0, halt = 1'b0;
  logic coil_a, coil_b, coil_a_oe, coil_b_oe;

  always #2 clk = ~clk;

  step_drive #(
    .WW(WW), .PW(PW), .CHOP_LEN(CHOP), .BURST_STEP(BS), .BURST_LEN(4), .BURST_EVERY(4),
    .FIRST_SAMPLE(FIRST), .SAMPLE_INTERVAL(INTV)
  ) uut (
    .clk(clk), .rst(rst), .tick(tick), .pulse_width(pulse_width), .period(period),
    .batt_lith(batt_lith), .batt_eol(batt_eol), .halt(halt),
    .coil_a(coil_a), .coil_b(coil_b), .coil_a_oe(coil_a_oe), .coil_b_oe(coil_b_oe)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference state: 0 silver, 1 lithium, 2 end-of-life
  int m_pcnt, m_grp, m_left, m_bs, m_w, m_lat, m_mode, m_scnt;
  bit m_act, m_pol, m_first, cur_halt;
  int rises, gaps;
  bit prev_on;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pcnt = 0; m_grp = 0; m_left = 0; m_bs = 0; m_w = 0; m_lat = 0;
    m_mode = 0; m_scnt = 0; m_act = 0; m_pol = 0; m_first = 1;
    prev_on = 0;
  endtask

  function automatic bit next_is_sample();
    return m_scnt == (m_first ? FIRST : INTV) - 1;
  endfunction

  task automatic model_step(input bit l, input bit e, input bit s);
    int old_mode = m_mode;
    bit st = 0;
    bit bnd;
    if (s) begin
      m_pcnt = 0; m_grp = 0; m_left = 0; m_bs = 0; m_act = 0;
    end else begin
      bnd = (m_pcnt == int'(period) - 1);
      if (m_left != 0) begin
        if (m_bs == BS - 1) begin st = 1; m_left--; m_bs = 0; end
        else m_bs++;
      end
      if (bnd) begin
        if (old_mode != 2) st = 1;
        else if (m_grp == 3) begin st = 1; m_left = 3; m_bs = 0; end
        m_grp = (m_grp + 1) % 4;
        m_pcnt = 0;
      end else m_pcnt++;
      if (st && !m_act) begin m_act = 1; m_w = 0; m_lat = old_mode; end
      else if (m_act) begin
        if (m_w == int'(pulse_width) - 1) begin m_act = 0; m_pol = ~m_pol; end
        else m_w++;
      end
    end
    if (next_is_sample()) begin
      m_mode = l ? 1 : (e ? 2 : 0);
      m_scnt = 0; m_first = 0;
    end else m_scnt++;
  endtask

  task automatic compare_now();
    bit drv = m_act && !(m_lat == 1 && (m_w % CHOP) == CHOP - 1);
    int expv = {drv && !m_pol && !cur_halt, drv && m_pol && !cur_halt, !cur_halt};
    int actv = {coil_a, coil_b, coil_a_oe & coil_b_oe};
    string tag;
    bit on = coil_a | coil_b;
    if (cur_halt) tag = "R9";
    else if (!m_act) tag = "R3";
    else if (m_lat == 1) tag = "R5";
    else if (m_lat == 2) tag = "R7";
    else tag = "R4";
    chk(tag, actv, expv, "coils {a,b,oe}");
    if (on && !prev_on) rises++;
    if (m_act && m_lat == 0 && !cur_halt && !on) gaps++;
    prev_on = on;
  endtask

  task automatic step(input bit l, input bit e, input bit s);
    @(negedge clk);
    batt_lith = l; batt_eol = e; halt = s; tick = 1'b1; cur_halt = s;
    @(negedge clk);
    tick = 1'b0;
    model_step(l, e, s);
    @(negedge clk);
    @(negedge clk);
    compare_now();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int fp_state, fp_hi, n, which;
    bit l, e, s;
    void'($urandom(32'd20231));
    repeat (4) @(negedge clk);
    // R1: values held during reset
    chk("R1", coil_a, 0, "coil_a in reset");
    chk("R1", coil_b, 0, "coil_b in reset");
    chk("R1", coil_a_oe & coil_b_oe, 1, "oe in reset");
    rst = 1'b0;
    model_reset();

    // phase A: lithium raised; sample tick equals first boundary (R8)
    fp_state = 0; fp_hi = 0;
    for (int i = 0; i < 130; i++) begin
      step(1, 0, 0);
      if (fp_state == 0 && (coil_a | coil_b)) begin
        fp_state = 1;
        chk("R2", {coil_a, coil_b}, 2'b10, "first pulse polarity");
      end
      if (fp_state == 1) begin
        if (coil_a | coil_b) fp_hi++;
        else begin
          fp_state = 2;
          chk("R8", fp_hi, int'(pulse_width), "first pulse solid ticks");
        end
      end
    end

    // phase B: flags toggle except on sample ticks (R6)
    for (int i = 0; i < 150; i++) step(next_is_sample() ? 0 : 1, 0, 0);
    gaps = 0;
    for (int i = 0; i < 400; i++) begin
      l = next_is_sample() ? 0 : 1'($urandom % 2);
      e = next_is_sample() ? 0 : 1'($urandom % 2);
      step(l, e, 0);
    end
    chk("R6", gaps, 0, "gaps in silver pulses");

    // phase C: end-of-life burst grouping (R7)
    for (int i = 0; i < 210; i++) step(0, 1, 1);
    rises = 0;
    for (int i = 0; i < 4 * int'(period) - 1; i++) step(0, 1, 0);
    chk("R7", rises, 0, "pulses before 4th boundary");
    for (int i = 0; i < 3 * BS + int'(pulse_width) + 2; i++) step(0, 1, 0);
    chk("R7", rises, 4, "pulses in one group");

    // phase D: random flags, halts and settings
    for (int i = 0; i < 2500; i++) begin
      if ($urandom % 120 == 0) begin
        pulse_width = WW'(2 + $urandom % 6);
        period = PW'(32 + $urandom % 17);
        for (int k = 0; k < 1 + int'($urandom % 20); k++) step(1'($urandom % 2), 1'($urandom % 2), 1);
      end else begin
        l = ($urandom % 4 == 0);
        e = ($urandom % 3 == 0);
        step(l, e, 0);
      end
    end

    // phase E: period from release and halt during a pulse (R4, R9)
    pulse_width = 8'd6; period = 16'd40;
    for (int i = 0; i < 210; i++) step(0, 0, 1);
    n = 0;
    do begin step(0, 0, 0); n++; end while (!(coil_a | coil_b) && n < 200);
    chk("R4", n, int'(period), "ticks from release to pulse");
    which = coil_a ? 1 : 2;
    step(0, 0, 1);
    chk("R9", {coil_a, coil_b, coil_a_oe, coil_b_oe}, 0, "outputs under halt");
    n = 0;
    do begin step(0, 0, 0); n++; end while (!(coil_a | coil_b) && n < 200);
    chk("R4", n, int'(period), "ticks after second release");
    chk("R9", coil_a ? 1 : 2, which, "polarity kept over dropped pulse");
    for (int i = 0; i < 3 * int'(period); i++) step(0, 0, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule